// File: doc/BRIEF.md
# I2C Address Watcher with Bus Status

This block listens to an I2C bus from inside a synchronous design. It brings SCL and SDA into the system clock domain and finds START and STOP conditions. It collects the first byte after every START, including a repeated START, and compares the address part of that byte with an own address that software programs. From this it keeps a bus-busy indication and several status flags: a match flag, a flag for the all-zero (general call) address, and the level of the last acknowledge bit. It also takes in an arbitration-lost input from elsewhere and shows it as a flag.

Software uses a small register port with three registers. The control/status register holds the role mode, the serial output enable and the status bits. The own-address register and the data shift register are write-protected in opposite senses by the serial output enable. The own address can change only while serial output is off. The data register accepts software writes only while serial output is on. While serial output is on, it also captures each byte received from the bus.

Top module: `i2c_addr_watch`

## Requirements
- R1: After reset, busy_o, addr_match_o, addr_zero_o, last_bit_o, mode_o and out_en_o are 0, and all three registers read 0x00.
- R2: The control register (select 0) reads {mode[7:6], busy[5], out_en[4], arb[3], match[2], zero[1], last[0]}. A write to it sets mode from bits [7:6] and out_en from bit 4, and mode_o shows the mode. Mode values: 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit. Mode changes only on a write to the control register.
- R3: An SDA fall while SCL is high (START) sets busy_o. An SDA rise while SCL is high (STOP) clears it.
- R4: A write to the own-address register (select 1) takes effect only while out_en is 0. The register can be read at any time.
- R5: A software write to the data register (select 2) takes effect only while out_en is 1.
- R6: addr_match_o is set when bits [7:1] of the first byte after a START equal own-address bits [7:1]. Bit 0 of both is ignored. Otherwise addr_match_o is 0.
- R7: addr_zero_o is set when the first byte after a START is 0x00. Zero bytes later in the transfer do not set it.
- R8: addr_match_o and addr_zero_o clear on every START, including a repeated START, and on every STOP.
- R9: last_bit_o takes the SDA level sampled on the ninth SCL rise of each frame: 0 for ACK, 1 for no ACK. START and STOP leave it unchanged.
- R10: While out_en is 1, each received byte (address or data) is loaded into the data register, MSB first. While out_en is 0, received bytes leave the register unchanged.
- R11: Control bit 3 shows arb_lost_i, registered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| arb_lost_i | input | 1 | Arbitration-lost indication from outside |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 own address, 2 data |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| busy_o | output | 1 | Bus busy |
| addr_match_o | output | 1 | Own address received |
| addr_zero_o | output | 1 | All-zero address received |
| last_bit_o | output | 1 | Last acknowledge bit level |
| mode_o | output | 2 | Role mode field |
| out_en_o | output | 1 | Serial output enable |

## Verification
The assertions check on every cycle the properties that tie one event to one response. A START or STOP moves busy and clears both address flags. The own-address and data registers stay frozen in the phase of out_en that locks them. The mode changes only after a control write. Only the bench scenarios can show the byte-level behaviour: that the comparison ignores bit 0, that a zero data byte does not set the zero flag, that the ACK level of each frame lands in last_bit_o, and that a repeated START starts a fresh address compare. They also show the register layout and the arbitration mirror.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_OWN  = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } mode_e;

  localparam int unsigned CTRL_OE_BIT = 4;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  // lines idle high, so reset to 1 to avoid false edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_frame_rx.sv
module i2c_frame_rx #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          byte_valid_o,
  output logic [DW-1:0] byte_o,
  output logic          byte_is_addr_o,
  output logic          ack_valid_o
);
  localparam int unsigned CNT_W = $clog2(DW + 2);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DW - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(DW);

  logic             active, in_addr;
  logic [CNT_W-1:0] bit_cnt;
  logic [DW-1:0]    shreg;
  logic             take;

  assign take = active & scl_rise_i & ~start_i & ~stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active  <= 1'b0;
      in_addr <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (start_i) begin
      active  <= 1'b1;
      in_addr <= 1'b1;
      bit_cnt <= '0;
    end else if (stop_i) begin
      active  <= 1'b0;
      in_addr <= 1'b0;
      bit_cnt <= '0;
    end else if (take) begin
      if (bit_cnt == ACK_SLOT) begin
        bit_cnt <= '0;
        in_addr <= 1'b0;
      end else begin
        shreg   <= {shreg[DW-2:0], sda_i};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign byte_valid_o   = take & (bit_cnt == LAST_DATA);
  assign byte_o         = {shreg[DW-2:0], sda_i};
  assign byte_is_addr_o = in_addr;
  assign ack_valid_o    = take & (bit_cnt == ACK_SLOT);
endmodule

// File: rtl/i2c_watch_regs.sv
module i2c_watch_regs
  import i2c_watch_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic [5:0]    status_i,
  output logic [1:0]    mode_o,
  output logic          out_en_o,
  output logic [DW-1:0] own_o,
  output logic [DW-1:0] data_o
);
  logic [1:0]    mode_q;
  logic          oe_q;
  logic [DW-1:0] own_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SLV_RX;
      oe_q   <= 1'b0;
      own_q  <= '0;
      data_q <= '0;
    end else begin
      if (we_i && sel_i == SEL_CTRL) begin
        mode_q <= wdata_i[DW-1:DW-2];
        oe_q   <= wdata_i[CTRL_OE_BIT];
      end
      if (we_i && sel_i == SEL_OWN && !oe_q) own_q <= wdata_i;
      // bus capture wins over a software write in the same cycle
      if (rx_valid_i && oe_q)                       data_q <= rx_byte_i;
      else if (we_i && sel_i == SEL_DATA && oe_q)   data_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_CTRL: rdata_o = DW'({mode_q, status_i[5], oe_q, status_i[3:0]});
      SEL_OWN:  rdata_o = own_q;
      SEL_DATA: rdata_o = data_q;
      default:  rdata_o = '0;
    endcase
  end

  assign mode_o   = mode_q;
  assign out_en_o = oe_q;
  assign own_o    = own_q;
  assign data_o   = data_q;
endmodule

// File: rtl/i2c_addr_watch.sv
module i2c_addr_watch #(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          arb_lost_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          busy_o,
  output logic          addr_match_o,
  output logic          addr_zero_o,
  output logic          last_bit_o,
  output logic [1:0]    mode_o,
  output logic          out_en_o
);
  logic          sda_s, scl_rise, start_det, stop_det;
  logic          byte_valid, byte_is_addr, ack_valid;
  logic [DW-1:0] rx_byte, own_addr, data_reg;
  logic          busy_q, match_q, zero_q, last_q, arb_q;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_frame_rx #(.DW(DW)) u_frame (
    .clk_i, .rst_ni,
    .sda_i          (sda_s),
    .scl_rise_i     (scl_rise),
    .start_i        (start_det),
    .stop_i         (stop_det),
    .byte_valid_o   (byte_valid),
    .byte_o         (rx_byte),
    .byte_is_addr_o (byte_is_addr),
    .ack_valid_o    (ack_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      match_q <= 1'b0;
      zero_q  <= 1'b0;
      last_q  <= 1'b0;
      arb_q   <= 1'b0;
    end else begin
      arb_q <= arb_lost_i;
      if (start_det)     busy_q <= 1'b1;
      else if (stop_det) busy_q <= 1'b0;
      if (start_det || stop_det) begin
        match_q <= 1'b0;
        zero_q  <= 1'b0;
      end else if (byte_valid && byte_is_addr) begin
        match_q <= (rx_byte[DW-1:1] == own_addr[DW-1:1]);
        zero_q  <= (rx_byte == '0);
      end
      if (ack_valid) last_q <= sda_s;
    end
  end

  i2c_watch_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .rx_valid_i (byte_valid),
    .rx_byte_i  (rx_byte),
    .status_i   ({busy_q, 1'b0, arb_q, match_q, zero_q, last_q}),
    .mode_o     (mode_o),
    .out_en_o   (out_en_o),
    .own_o      (own_addr),
    .data_o     (data_reg)
  );

  assign busy_o       = busy_q;
  assign addr_match_o = match_q;
  assign addr_zero_o  = zero_q;
  assign last_bit_o   = last_q;
endmodule

// File: rtl/i2c_addr_watch_chk.sv
module i2c_addr_watch_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          stop_i,
  input logic          busy_i,
  input logic          match_i,
  input logic          zero_i,
  input logic          out_en_i,
  input logic          we_i,
  input logic [1:0]    sel_i,
  input logic [1:0]    mode_i,
  input logic [DW-1:0] own_i,
  input logic [DW-1:0] data_i
);
  AST_BUSY_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_i); // R3
  AST_IDLE_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !busy_i); // R3
  AST_FLAGS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || stop_i) |=> (!match_i && !zero_i)); // R8
  AST_OWN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_i |=> $stable(own_i)); // R4
  AST_DATA_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_i |=> $stable(data_i)); // R10
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i == 2'd0) |=> $stable(mode_i)); // R2
endmodule

bind i2c_addr_watch i2c_addr_watch_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_det),
  .stop_i   (stop_det),
  .busy_i   (busy_o),
  .match_i  (addr_match_o),
  .zero_i   (addr_zero_o),
  .out_en_i (out_en_o),
  .we_i     (reg_we_i),
  .sel_i    (reg_sel_i),
  .mode_i   (mode_o),
  .own_i    (own_addr),
  .data_i   (data_reg)
);

// File: tb/tb_i2c_addr_watch.sv
`timescale 1ns/1ps
module tb_i2c_addr_watch;
  localparam int H = 10;
  localparam int WATCHDOG = 200000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_i = 1'b1, sda_i = 1'b1, arb_lost_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_sel_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'h00;
  logic [7:0] reg_rdata_o;
  logic       busy_o, addr_match_o, addr_zero_o, last_bit_o, out_en_o;
  logic [1:0] mode_o;

  always #2 clk_i = ~clk_i;

  i2c_addr_watch dut (
    .clk_i, .rst_ni, .scl_i, .sda_i, .arb_lost_i,
    .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o,
    .busy_o, .addr_match_o, .addr_zero_o, .last_bit_o, .mode_o, .out_en_o
  );

  typedef enum int {K_BUSY, K_MATCH, K_ZERO, K_LAST, K_RDATA, K_MODE, K_OE} kind_e;
  typedef struct {
    kind_e      kind;
    string      req;
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  function automatic logic [7:0] actual(kind_e k);
    case (k)
      K_BUSY:  return {7'd0, busy_o};
      K_MATCH: return {7'd0, addr_match_o};
      K_ZERO:  return {7'd0, addr_zero_o};
      K_LAST:  return {7'd0, last_bit_o};
      K_RDATA: return reg_rdata_o;
      K_MODE:  return {6'd0, mode_o};
      default: return {7'd0, out_en_o};
    endcase
  endfunction

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        item_t it;
        logic [7:0] a;
        it = q.pop_front();
        a = actual(it.kind);
        n_chk++;
        if (a !== it.exp) begin
          n_fail++;
          $display("FAIL %s (%s): actual %h expected %h", it.req, it.kind.name(), a, it.exp);
        end
      end
    end
  end

  task automatic expect_v(kind_e k, string req, logic [7:0] e);
    item_t it;
    it.kind = k; it.req = req; it.exp = e;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk_i);
  endtask

  task automatic expect_reg(logic [1:0] sel, string req, logic [7:0] e);
    @(negedge clk_i);
    reg_sel_i = sel;
    expect_v(K_RDATA, req, e);
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk_i);
    reg_sel_i = sel; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic hold(); repeat (H) @(negedge clk_i); endtask

  task automatic bus_start();
    sda_i = 1'b0; hold(); scl_i = 1'b0; hold();
  endtask
  task automatic bus_rstart();
    sda_i = 1'b1; hold(); scl_i = 1'b1; hold(); sda_i = 1'b0; hold(); scl_i = 1'b0; hold();
  endtask
  task automatic bus_stop();
    sda_i = 1'b0; hold(); scl_i = 1'b1; hold(); sda_i = 1'b1; hold();
  endtask
  task automatic bus_bit(logic b);
    sda_i = b; hold(); scl_i = 1'b1; hold(); scl_i = 1'b0; hold();
  endtask
  task automatic bus_frame(logic [7:0] d, logic ack);
    for (int i = 7; i >= 0; i--) bus_bit(d[i]);
    bus_bit(ack);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R1 reset state
    expect_v(K_BUSY, "R1", 8'h00);
    expect_v(K_MATCH, "R1", 8'h00);
    expect_v(K_ZERO, "R1", 8'h00);
    expect_v(K_LAST, "R1", 8'h00);
    expect_v(K_MODE, "R1", 8'h00);
    expect_v(K_OE, "R1", 8'h00);
    expect_reg(2'd0, "R1", 8'h00);
    expect_reg(2'd1, "R1", 8'h00);
    expect_reg(2'd2, "R1", 8'h00);

    // R4 own address writable with out_en=0; R5 data write ignored
    wr(2'd1, 8'h54);
    expect_reg(2'd1, "R4", 8'h54);
    wr(2'd2, 8'h3C);
    expect_reg(2'd2, "R5", 8'h00);

    // R2 mode 10 and out_en on
    wr(2'd0, 8'h90);
    expect_v(K_MODE, "R2", 8'h02);
    expect_v(K_OE, "R2", 8'h01);
    wr(2'd1, 8'h22);
    expect_reg(2'd1, "R4", 8'h54);
    wr(2'd2, 8'hA5);
    expect_reg(2'd2, "R5", 8'hA5);

    // R3 START -> busy; R6 match with bit0 differing
    bus_start();
    expect_v(K_BUSY, "R3", 8'h01);
    bus_frame(8'h55, 1'b0);
    expect_v(K_MATCH, "R6", 8'h01);
    expect_v(K_ZERO, "R7", 8'h00);
    expect_v(K_LAST, "R9", 8'h00);
    expect_reg(2'd2, "R10", 8'h55);
    expect_reg(2'd0, "R2", 8'hB4);

    // R7 zero data byte is not an address; R9 NACK
    bus_frame(8'h00, 1'b1);
    expect_v(K_ZERO, "R7", 8'h00);
    expect_v(K_LAST, "R9", 8'h01);
    expect_v(K_MATCH, "R6", 8'h01);
    expect_reg(2'd2, "R10", 8'h00);

    // R3 / R8 STOP
    bus_stop();
    expect_v(K_BUSY, "R3", 8'h00);
    expect_v(K_MATCH, "R8", 8'h00);
    expect_v(K_LAST, "R9", 8'h01);

    // R7 general call, R8 repeated START clears, then match
    bus_start();
    bus_frame(8'h00, 1'b0);
    expect_v(K_ZERO, "R7", 8'h01);
    expect_v(K_MATCH, "R6", 8'h00);
    expect_v(K_LAST, "R9", 8'h00);
    bus_rstart();
    expect_v(K_ZERO, "R8", 8'h00);
    expect_v(K_BUSY, "R3", 8'h01);
    bus_frame(8'h54, 1'b0);
    expect_v(K_MATCH, "R6", 8'h01);
    bus_rstart();
    expect_v(K_MATCH, "R8", 8'h00);
    bus_frame(8'h56, 1'b1);
    expect_v(K_MATCH, "R6", 8'h00);
    expect_v(K_LAST, "R9", 8'h01);
    expect_reg(2'd2, "R10", 8'h56);
    bus_stop();

    // R10 out_en off: receive leaves data register
    wr(2'd0, 8'h00);
    expect_v(K_OE, "R2", 8'h00);
    bus_start();
    bus_frame(8'hC3, 1'b0);
    expect_reg(2'd2, "R10", 8'h56);
    expect_v(K_MATCH, "R6", 8'h00);
    bus_stop();

    // R2 other modes
    wr(2'd0, 8'hC0);
    expect_v(K_MODE, "R2", 8'h03);
    wr(2'd0, 8'h40);
    expect_v(K_MODE, "R2", 8'h01);
    expect_reg(2'd0, "R2", 8'h40);

    // R11 arbitration mirror
    @(negedge clk_i); arb_lost_i = 1'b1;
    repeat (2) @(negedge clk_i);
    expect_reg(2'd0, "R11", 8'h48);
    @(negedge clk_i); arb_lost_i = 1'b0;
    repeat (2) @(negedge clk_i);
    expect_reg(2'd0, "R11", 8'h40);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule